// File: doc/BRIEF.md
# Configurable Serial Receiver with Idle Timeout

This block turns an asynchronous serial line into bytes. A baud generator supplies a sample tick at sixteen times the bit rate. The receiver uses these ticks to find each start bit and to sample every later bit at its centre. The character length, the parity rule and the number of stop bits come from a mode word. Each finished character goes into a 16-entry receive FIFO. Software, or a DMA engine, drains the FIFO through a show-ahead read port.

Toward an interrupt controller the block gives one-cycle pulses for parity errors, framing errors, overruns and line-idle timeouts. It also gives a level flag that is set while the FIFO fill is at or above a programmable watermark. A control strobe resets the receive path, enables or disables the receiver, and rearms the idle timer. A mode field routes the local transmit stream into the receiver in place of the external pin.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset the FIFO is empty (count 0), the receiver is disabled (`rx_on` = 0), `trig_flag` is 0 and no pulse output fires.
- R2: `mode_cfg[2:1]` selects the character length: 00 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits, and 01 is treated as 8. Data arrives LSB first. Bits above the character length read as zero in `rd_data`.
- R3: `mode_cfg[5:3]` selects parity. 000 is even, 001 is odd, 010 is a parity bit that must be 0, 011 is a parity bit that must be 1, and 1xx means no parity bit. A mismatched parity bit raises a one-cycle `parity_err` pulse. The character is still stored.
- R4: `mode_cfg[7:6]` = 10 selects two stop bits; any other value selects one. A 0 in the first stop slot raises a one-cycle `frame_err` pulse. The character is still stored.
- R5: The line is sampled on `sample_tick`, 16 ticks per bit. A low level starts a frame only if it is still low 8 ticks later. A high level at that point returns the receiver to idle.
- R6: The FIFO holds 16 characters and returns them in arrival order. A character that completes while the FIFO is full is dropped and raises `overrun_err` instead of the error pulses. A read of an empty FIFO has no effect.
- R7: `trig_flag` is 1 exactly while `trig_level` is nonzero and `rx_count` >= `trig_level`. A level of 0, or a level above 16, never sets it.
- R8: With `ctrl_we` high, `ctrl_cmd[1]` enables the receiver and `ctrl_cmd[2]` disables it, and disable wins if both are set. A disabled receiver ignores the line and stores nothing.
- R9: With `ctrl_we` high, `ctrl_cmd[0]` empties the FIFO and returns the receiver to idle.
- R10: After each completed frame, `timeout_evt` pulses once after 4 x `tmo_value` bit periods (64 x `tmo_value` ticks) unless a new start bit arrives first. A new start bit cancels the pending timeout. A new frame rearms it. A value of 0 never raises the event.
- R11: With `ctrl_we` high, `ctrl_cmd[3]` rearms the idle timer with the full interval, even after it has already fired.
- R12: `mode_cfg[9:8]` = 10 feeds `tx_loop` to the receiver in place of `rx_serial`. In any other mode `tx_loop` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversampling enable, 16 per bit |
| rx_serial | input | 1 | External serial line |
| tx_loop | input | 1 | Local transmit stream for loopback |
| mode_cfg | input | 9 | Frame format and channel mode, bits [9:1] |
| ctrl_we | input | 1 | Control command strobe |
| ctrl_cmd | input | 4 | {rearm timer, disable, enable, reset path} |
| trig_level | input | 6 | FIFO watermark |
| tmo_value | input | 8 | Idle timeout interval, 0 disables |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head (show-ahead) |
| rx_count | output | 5 | FIFO fill count |
| rx_empty | output | 1 | FIFO empty |
| rx_full | output | 1 | FIFO full |
| rx_on | output | 1 | Receiver enabled |
| trig_flag | output | 1 | Fill at or above watermark |
| parity_err | output | 1 | Parity error pulse |
| frame_err | output | 1 | Framing error pulse |
| overrun_err | output | 1 | Overrun pulse |
| timeout_evt | output | 1 | Idle timeout pulse |

## Verification
If the bit counter or the sample phase drifts, the next character shows it. Its data is shifted or cut short in `rd_data`, or a spurious parity or framing pulse appears, within one frame time. If the FIFO pointers or the count go wrong, it shows on the next pop, as data out of order, or at the full boundary, as a missing or extra `overrun_err`. A wrong idle counter load shows as `timeout_evt` arriving outside a window of a few dozen ticks around 64 x `tmo_value` ticks after the stop bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;

  typedef enum logic [2:0] {
    PAR_EVEN, PAR_ODD, PAR_ZERO, PAR_ONE, PAR_NONE
  } par_mode_t;

  typedef struct packed {
    logic [3:0] nbits;
    par_mode_t  par;
    logic       two_stop;
    logic       loopback;
  } rx_cfg_t;

  // Mode word decode; bit positions are part of the software contract.
  function automatic rx_cfg_t decode_mode(input logic [9:1] m);
    rx_cfg_t c;
    case (m[2:1])
      2'b10:   c.nbits = 4'd7;
      2'b11:   c.nbits = 4'd6;
      default: c.nbits = 4'd8;
    endcase
    if (m[5]) c.par = PAR_NONE;
    else begin
      case (m[4:3])
        2'b00:   c.par = PAR_EVEN;
        2'b01:   c.par = PAR_ODD;
        2'b10:   c.par = PAR_ZERO;
        default: c.par = PAR_ONE;
      endcase
    end
    c.two_stop = (m[7:6] == 2'b10);
    c.loopback = (m[9:8] == 2'b10);
    return c;
  endfunction

  function automatic logic [7:0] len_mask(input logic [3:0] n);
    return 8'hFF >> (4'd8 - n);
  endfunction

  // Value the parity slot must carry for a given character.
  function automatic logic want_parity(input par_mode_t p, input logic [7:0] d,
                                       input logic [3:0] n);
    logic x;
    x = ^(d & len_mask(n));
    case (p)
      PAR_EVEN: return x;
      PAR_ODD:  return ~x;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        tick,
  input  logic        line,
  input  rx_cfg_t     cfg,
  output logic        done,
  output logic [7:0]  data,
  output logic        par_bad,
  output logic        frm_bad,
  output logic        start_seen
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_C = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

  rx_state_t      st;
  logic [CW-1:0]  cnt;
  logic [3:0]     bidx;
  logic [7:0]     shreg;
  logic           par_bit;
  logic           ferr;
  logic           at_sample;

  assign at_sample = tick && (cnt == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0; par_bit <= 1'b0; ferr <= 1'b0;
    end else if (clr) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0; par_bit <= 1'b0; ferr <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          if (!line) begin
            st  <= S_START;
            cnt <= '0;
          end
        end
        S_START: begin
          if (cnt == HALF_C) begin
            cnt <= '0;
            if (!line) begin
              st    <= S_DATA;
              bidx  <= '0;
              shreg <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == LAST_C) begin
            cnt <= '0;
            shreg[bidx[2:0]] <= line;
            if (bidx == cfg.nbits - 4'd1)
              st <= (cfg.par == PAR_NONE) ? S_STOP1 : S_PAR;
            else
              bidx <= bidx + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt == LAST_C) begin
            cnt     <= '0;
            par_bit <= line;
            st      <= S_STOP1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP1: begin
          if (cnt == LAST_C) begin
            cnt  <= '0;
            ferr <= !line;
            st   <= cfg.two_stop ? S_STOP2 : S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP2: begin
          if (cnt == LAST_C) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = at_sample && ((st == S_STOP1 && !cfg.two_stop) || st == S_STOP2);
  assign data       = shreg;
  assign frm_bad    = done && ((st == S_STOP1) ? !line : ferr);
  assign par_bad    = done && (cfg.par != PAR_NONE) &&
                      (par_bit != want_parity(cfg.par, shreg, cfg.nbits));
  assign start_seen = tick && (st == S_IDLE) && !line;

  // A high line seen while idle keeps the receiver idle.
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && tick && line && !clr) |=> (st == S_IDLE));

  // A false start (line high at mid-bit) never reaches the data state.
  assert_false_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == HALF_C && line && !clr) |=> (st == S_IDLE));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr,
  input  logic [W-1:0]             wdata,
  input  logic                     rd,
  output logic [W-1:0]             rdata,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // A write while full, with no read, leaves the fill unchanged.
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd && !clr) |=> (count == DEPTH_C));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  assert_reset_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
  parameter int OVS = 16,
  parameter int TW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          arm,
  input  logic          restart,
  input  logic          hold,
  input  logic [TW-1:0] tmo_val,
  output logic          tmo_pulse
);
  localparam int CW = $clog2(OVS);
  localparam int LW = TW + 2;
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

  logic          armed;
  logic [CW-1:0] pre;
  logic [LW-1:0] left;

  assign tmo_pulse = armed && tick && (pre == LAST_C) && (left == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; pre <= '0; left <= '0;
    end else if (clr || hold) begin
      armed <= 1'b0; pre <= '0;
    end else if (arm || restart) begin
      armed <= (tmo_val != '0);
      pre   <= '0;
      left  <= {tmo_val, 2'b00};
    end else if (armed && tick) begin
      if (pre == LAST_C) begin
        pre  <= '0;
        left <= left - 1'b1;
        if (left == LW'(1)) armed <= 1'b0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assert_single_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse && !arm && !restart) |=> !tmo_pulse);

  assert_start_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> !tmo_pulse);

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_tick,
  input  logic                   rx_serial,
  input  logic                   tx_loop,
  input  logic [9:1]             mode_cfg,
  input  logic                   ctrl_we,
  input  logic [3:0]             ctrl_cmd,
  input  logic [5:0]             trig_level,
  input  logic [7:0]             tmo_value,
  input  logic                   rd_en,
  output logic [7:0]             rd_data,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic                   rx_empty,
  output logic                   rx_full,
  output logic                   rx_on,
  output logic                   trig_flag,
  output logic                   parity_err,
  output logic                   frame_err,
  output logic                   overrun_err,
  output logic                   timeout_evt
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  rx_cfg_t    cfg;
  logic       path_rst, frame_clr, restart_tmo;
  logic [1:0] sync_q;
  logic       line_s;
  logic       char_done, char_par, char_frm, start_seen;
  logic [7:0] char_data;

  assign cfg         = decode_mode(mode_cfg);
  assign path_rst    = ctrl_we && ctrl_cmd[0];
  assign restart_tmo = ctrl_we && ctrl_cmd[3];
  assign frame_clr   = path_rst || !rx_on;

  // Enable/disable; disable wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rx_on <= 1'b0;
    else if (ctrl_we && ctrl_cmd[2])  rx_on <= 1'b0;
    else if (ctrl_we && ctrl_cmd[1])  rx_on <= 1'b1;
  end

  // Line select and two-stage synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], cfg.loopback ? tx_loop : rx_serial};
  end
  assign line_s = sync_q[1];

  srx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .tick(sample_tick), .line(line_s),
    .cfg(cfg), .done(char_done), .data(char_data), .par_bad(char_par),
    .frm_bad(char_frm), .start_seen(start_seen)
  );

  srx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(path_rst), .wr(char_done),
    .wdata(char_data & len_mask(cfg.nbits)), .rd(rd_en), .rdata(rd_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  srx_idle_timer #(.OVS(OVS), .TW(8)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .tick(sample_tick),
    .arm(char_done), .restart(restart_tmo), .hold(start_seen),
    .tmo_val(tmo_value), .tmo_pulse(timeout_evt)
  );

  assign overrun_err = char_done && rx_full;
  assign parity_err  = char_done && !rx_full && char_par;
  assign frame_err   = char_done && !rx_full && char_frm;
  assign trig_flag   = (trig_level != 6'd0) && (6'(rx_count) >= trig_level);

  assert_overrun_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> (rx_count == CNTW'(DEPTH) || $past(rd_en) || $past(path_rst)));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && $past(!rx_on)) |-> !char_done);

  assert_trig_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flag |-> !rx_empty);

  assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |-> !(parity_err || frame_err));

endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1, tx_loop = 1'b1;
  logic [9:1] mode_cfg = '0;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_cmd = '0;
  logic [5:0] trig_level = '0;
  logic [7:0] tmo_value = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic       rx_empty, rx_full, rx_on, trig_flag;
  logic       parity_err, frame_err, overrun_err, timeout_evt;

  int n_chk = 0, n_fail = 0;
  int n_par = 0, n_frm = 0, n_ovr = 0, n_tmo = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_unit u_serial_rx_unit (
    .clk(clk), .rst_n(rst_n), .sample_tick(1'b1), .rx_serial(rx_serial),
    .tx_loop(tx_loop), .mode_cfg(mode_cfg), .ctrl_we(ctrl_we), .ctrl_cmd(ctrl_cmd),
    .trig_level(trig_level), .tmo_value(tmo_value), .rd_en(rd_en), .rd_data(rd_data),
    .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full), .rx_on(rx_on),
    .trig_flag(trig_flag), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_err(overrun_err), .timeout_evt(timeout_evt)
  );

  always @(negedge clk) if (rst_n) begin
    if (parity_err)  n_par++;
    if (frame_err)   n_frm++;
    if (overrun_err) n_ovr++;
    if (timeout_evt) n_tmo++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [9:1] mk_mode(input int nb, input int pm, input bit two, input bit lp);
    logic [9:1] m;
    m = '0;
    m[2:1] = (nb == 7) ? 2'b10 : (nb == 6) ? 2'b11 : 2'b00;
    m[5:3] = (pm == 4) ? 3'b100 : 3'(pm);
    m[7:6] = two ? 2'b10 : 2'b00;
    m[9:8] = lp ? 2'b10 : 2'b00;
    return m;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b, input bit lp);
    if (lp) tx_loop = b; else rx_serial = b;
    idle(16);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input int pm, input bit two,
                            input bit flip, input bit bad, input bit lp);
    logic [7:0] msk;
    logic p;
    msk = 8'hFF >> (8 - nb);
    p = ^(d & msk);
    if (pm == 1) p = ~p;
    if (pm == 2) p = 1'b0;
    if (pm == 3) p = 1'b1;
    if (flip) p = ~p;
    put_bit(1'b0, lp);
    for (int i = 0; i < nb; i++) put_bit(d[i], lp);
    if (pm != 4) put_bit(p, lp);
    put_bit(!bad, lp);
    if (two) put_bit(1'b1, lp);
    put_bit(1'b1, lp);
  endtask

  task automatic command(input logic [3:0] c);
    ctrl_cmd = c; ctrl_we = 1'b1;
    idle(1);
    ctrl_we = 1'b0; ctrl_cmd = '0;
    idle(1);
  endtask

  task automatic pop(input string req, input int exp);
    chk(req, int'(rd_data), exp);
    rd_en = 1'b1;
    idle(1);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 count", int'(rx_count), 0);
    chk("R1 empty", int'(rx_empty), 1);
    chk("R1 rx_on", int'(rx_on), 0);
    chk("R1 trig", int'(trig_flag), 0);
    command(4'b0010);
    chk("R8 enable", int'(rx_on), 1);

    // R2/R3/R4/R5 sweep over every format
    for (int nb = 6; nb <= 8; nb++)
      for (int pm = 0; pm <= 4; pm++)
        for (int two = 0; two <= 1; two++) begin
          logic [7:0] d1, d2, m;
          d1 = 8'((nb * 37 + pm * 11 + two * 5 + 3) & 255);
          d2 = ~d1;
          m = 8'hFF >> (8 - nb);
          mode_cfg = mk_mode(nb, pm, two[0], 1'b0);
          idle(2);
          send_frame(d1, nb, pm, two[0], 0, 0, 0);
          send_frame(d2, nb, pm, two[0], 0, 0, 0);
          chk("R6 count two", int'(rx_count), 2);
          chk("R7 level zero", int'(trig_flag), 0);
          pop("R2 data first", int'(d1 & m));
          pop("R2 data second", int'(d2 & m));
          chk("R6 drained", int'(rx_empty), 1);
        end
    chk("R3 no parity errors in sweep", n_par, 0);
    chk("R4 no framing errors in sweep", n_frm, 0);
    chk("R10 zero value never fires", n_tmo, 0);

    // R3 error cases
    mode_cfg = mk_mode(8, 0, 0, 0);
    idle(2);
    send_frame(8'hA5, 8, 0, 0, 1, 0, 0);
    chk("R3 even mismatch", n_par, 1);
    pop("R3 stored despite error", 8'hA5);
    mode_cfg = mk_mode(7, 3, 0, 0);
    idle(2);
    send_frame(8'h31, 7, 3, 0, 1, 0, 0);
    chk("R3 one-slot mismatch", n_par, 2);
    pop("R3 stored one-slot", 8'h31);
    mode_cfg = mk_mode(6, 2, 0, 0);
    idle(2);
    send_frame(8'h2A, 6, 2, 0, 1, 0, 0);
    chk("R3 zero-slot mismatch", n_par, 3);
    pop("R3 stored zero-slot", 8'h2A);

    // R4 framing on first stop of two
    mode_cfg = mk_mode(8, 4, 1, 0);
    idle(2);
    send_frame(8'h5C, 8, 4, 1, 0, 1, 0);
    chk("R4 framing pulse", n_frm, 1);
    chk("R4 no parity pulse", n_par, 3);
    pop("R4 stored despite framing", 8'h5C);

    // R5 short glitch is not a start bit
    rx_serial = 1'b0; idle(4); rx_serial = 1'b1; idle(40);
    chk("R5 glitch ignored", int'(rx_count), 0);

    // R7/R6 watermark, full, overrun, order
    mode_cfg = mk_mode(8, 4, 0, 0);
    trig_level = 6'd4;
    idle(2);
    for (int i = 0; i < 16; i++) begin
      send_frame(8'(8'h40 + i), 8, 4, 0, 0, 0, 0);
      if (i == 2) chk("R7 below level", int'(trig_flag), 0);
      if (i == 3) chk("R7 at level", int'(trig_flag), 1);
    end
    chk("R6 full", int'(rx_full), 1);
    send_frame(8'hEE, 8, 4, 0, 0, 0, 0);
    chk("R6 overrun pulse", n_ovr, 1);
    chk("R6 count stays 16", int'(rx_count), 16);
    trig_level = 6'd20;
    idle(1);
    chk("R7 level above depth", int'(trig_flag), 0);
    trig_level = 6'd0;
    for (int i = 0; i < 16; i++) pop("R6 order", 8'h40 + i);
    chk("R6 empty after drain", int'(rx_empty), 1);
    pop("R6 empty read", int'(rd_data));
    chk("R6 empty read no effect", int'(rx_count), 0);

    // R9 path reset
    send_frame(8'h11, 8, 4, 0, 0, 0, 0);
    send_frame(8'h22, 8, 4, 0, 0, 0, 0);
    chk("R9 before reset", int'(rx_count), 2);
    command(4'b0001);
    chk("R9 cleared", int'(rx_count), 0);
    chk("R9 still enabled", int'(rx_on), 1);

    // R8 disable, priority
    command(4'b0100);
    chk("R8 disabled", int'(rx_on), 0);
    send_frame(8'h77, 8, 4, 0, 0, 0, 0);
    chk("R8 ignored while off", int'(rx_count), 0);
    command(4'b0110);
    chk("R8 disable wins", int'(rx_on), 0);
    command(4'b0010);
    chk("R8 re-enabled", int'(rx_on), 1);

    // R12 loopback
    mode_cfg = mk_mode(8, 4, 0, 0);
    idle(2);
    send_frame(8'h99, 8, 4, 0, 0, 0, 1);
    chk("R12 tx_loop ignored in normal", int'(rx_count), 0);
    mode_cfg = mk_mode(8, 4, 0, 1);
    idle(2);
    send_frame(8'h3C, 8, 4, 0, 0, 0, 1);
    chk("R12 loop count", int'(rx_count), 1);
    pop("R12 loop data", 8'h3C);
    mode_cfg = mk_mode(8, 4, 0, 0);
    idle(2);

    // R10/R11 idle timeout (value 3 -> 192 ticks after the stop sample)
    tmo_value = 8'd3;
    send_frame(8'h01, 8, 4, 0, 0, 0, 0);
    idle(120);
    chk("R10 not before interval", n_tmo, 0);
    idle(80);
    chk("R10 fires once", n_tmo, 1);
    idle(250);
    chk("R10 single shot", n_tmo, 1);
    command(4'b1000);
    idle(150);
    chk("R11 not early after rearm", n_tmo, 1);
    idle(70);
    chk("R11 fires after rearm", n_tmo, 2);
    send_frame(8'h02, 8, 4, 0, 0, 0, 0);
    idle(100);
    send_frame(8'h03, 8, 4, 0, 0, 0, 0);
    idle(120);
    chk("R10 new start reloads", n_tmo, 2);
    idle(80);
    chk("R10 fires after second frame", n_tmo, 3);
    tmo_value = 8'd0;
    send_frame(8'h04, 8, 4, 0, 0, 0, 0);
    idle(400);
    chk("R10 zero disables", n_tmo, 3);

    report();
  end
endmodule